// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is a paired asynchronous serial transmitter and receiver whose character format is chosen at run time. Configuration inputs set the number of data bits (5 to 8), one of five parity behaviours (none, odd, even, a parity bit held at 1, a parity bit held at 0) and one or two stop bits. A single 32-bit baud word carries two independent 16-bit dividers, one per direction. Each divider is the number of clock cycles in one bit time, which is the input clock divided by the baud rate, rounded to the nearest integer.

The transmitter accepts a byte through a valid/ready handshake and shifts out a frame: a low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits. The line idles high. The receiver passes the line through a two-flop synchroniser and detects a falling edge. It confirms the start bit half a bit time later and samples every following bit at its middle. It then presents the rebuilt character together with parity, framing and overrun flags. The received character is held until it is acknowledged.

Both sides are finite state machines with the same five states. IDLE waits for work. START times the start bit. DATA moves the configured number of data bits. PARITY handles the optional parity bit. STOP times the stop bits. The transmitter goes from IDLE to START on an accepted handshake. It goes from START to DATA after one bit time. It goes from DATA to PARITY after the last data bit when parity is on, and from DATA to STOP when parity is off. It goes from PARITY to STOP after one bit time, and from STOP back to IDLE after one or two bit times. The receiver goes from IDLE to START on a low synchronised line. From START it returns to IDLE if the line is high at the half-bit check, and goes to DATA otherwise. Its moves from DATA through PARITY to STOP mirror the transmitter. It goes from STOP to IDLE at the middle of the first stop bit, which is also when the character is delivered. A low global enable forces both machines to IDLE. The format and divider inputs must be held steady unless the enable is low or the side concerned is idle.

Top module: `uart_frame_engine`

## Requirements
- R1: The data-width code selects the bits per character: code 0 gives 5, code 1 gives 6, code 2 gives 7 and code 3 gives 8. Data is sent least significant bit first, right after a low start bit.
- R2: The parity code selects the parity behaviour. Code 4 gives odd parity over the sent data bits. Code 6 gives even parity. Code 5 sends a 1 and code 7 sends a 0. Codes 0, 1, 2 and 3 send no parity bit. When present, the parity bit directly follows the last data bit.
- R3: The stop field set to 0 sends one high stop bit, and set to 1 sends two. A whole frame lasts the divider times (1 + data bits + parity bits + stop bits) cycles, counted from the accepting clock edge.
- R4: Bits 15:0 of the baud word give the transmit bit time in clock cycles, and bits 31:16 give the receive bit time. The two are independent.
- R5: tx_busy is high from the cycle after a handshake is accepted until the last stop bit ends. tx_ready is high only when the enable is high and the transmitter is idle.
- R6: The receiver rebuilds a character of the configured width in rx_data, with the unused upper bits set to zero. It holds rx_valid high until rx_ack is given.
- R7: In the parity modes (codes 4 to 7), rx_parity_err is set with the character when the received parity bit differs from the value the transmitter would send.
- R8: rx_frame_err is set with the character when the first stop bit is sampled low.
- R9: rx_overrun is set when a character completes while the previous one is still unacknowledged. The new character replaces the old one. rx_ack clears rx_valid and all three flags.
- R10: A low pulse on the receive line shorter than half a bit time is rejected and produces no character.
- R11: When the enable is low, tx_line is high, tx_ready and tx_busy are low, and both machines are idle. A frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable for both directions |
| width_code | input | 2 | Data width select (5 + code bits) |
| parity_code | input | 3 | Parity mode select |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| baud_word | input | 32 | [15:0] transmit divider, [31:16] receive divider |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can accept a character |
| tx_busy | output | 1 | A frame is being shifted out |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_ack | input | 1 | Consumes the held received character |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | A received character is held |
| rx_parity_err | output | 1 | Parity mismatch on the held character |
| rx_frame_err | output | 1 | Stop bit was low on the held character |
| rx_overrun | output | 1 | The held character replaced an unread one |

## Verification
A wrong transmit state or bit counter shows on tx_line within one bit time, as a misplaced start, data, parity or stop level. It also moves the cycle at which tx_ready returns, so a frame of the wrong length is caught at its last cycle. A receive machine that samples off-centre or miscounts bits delivers a wrong rx_data or a spurious error flag about half a bit time after the stop bit begins. A machine that never returns to IDLE shows as a missing rx_valid or a stuck tx_busy on the next frame. The sweep over every width, parity and stop combination, together with the glitch, disable, overrun and split-divider cases, puts each transition where a fault would show.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } frame_state_t;

    function automatic logic [2:0] last_index(input logic [1:0] code);
        return 3'd4 + {1'b0, code};
    endfunction

    function automatic logic [7:0] char_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

    function automatic logic parity_on(input logic [2:0] code);
        return code[2];
    endfunction

    function automatic logic parity_bit(input logic [2:0] code, input logic [7:0] d);
        case (code)
            3'd4:    return ~(^d);
            3'd5:    return 1'b1;
            3'd6:    return ^d;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
    import sfe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       width_code,
    input  logic [2:0]       parity_code,
    input  logic             two_stop,
    input  logic [DIV_W-1:0] div,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             tx_busy,
    output logic             tx_line
);
    frame_state_t     state;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       idx;
    logic [7:0]       shreg;
    logic             pbit;
    logic             second_stop;
    logic             bit_end;

    assign bit_end = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            idx         <= '0;
            shreg       <= '0;
            pbit        <= 1'b0;
            second_stop <= 1'b0;
        end else if (!enable) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (tx_valid) begin
                    shreg <= tx_data & char_mask(width_code);
                    pbit  <= parity_bit(parity_code, tx_data & char_mask(width_code));
                    cnt   <= div - 1'b1;
                    state <= ST_START;
                end
                ST_START: if (bit_end) begin
                    cnt   <= div - 1'b1;
                    idx   <= '0;
                    state <= ST_DATA;
                end else cnt <= cnt - 1'b1;
                ST_DATA: if (bit_end) begin
                    cnt         <= div - 1'b1;
                    shreg       <= shreg >> 1;
                    idx         <= idx + 1'b1;
                    second_stop <= 1'b0;
                    if (idx == last_index(width_code))
                        state <= parity_on(parity_code) ? ST_PARITY : ST_STOP;
                end else cnt <= cnt - 1'b1;
                ST_PARITY: if (bit_end) begin
                    cnt   <= div - 1'b1;
                    state <= ST_STOP;
                end else cnt <= cnt - 1'b1;
                ST_STOP: if (bit_end) begin
                    if (two_stop && !second_stop) begin
                        second_stop <= 1'b1;
                        cnt         <= div - 1'b1;
                    end else state <= ST_IDLE;
                end else cnt <= cnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_busy  = (state != ST_IDLE);
        tx_ready = enable && (state == ST_IDLE);
        unique case (state)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shreg[0];
            ST_PARITY: tx_line = pbit;
            default:   tx_line = 1'b1;
        endcase
    end

    assert_accept_starts_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (tx_busy && !tx_line));

    assert_disable_idles_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tx_busy && tx_line));

endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
    import sfe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       width_code,
    input  logic [2:0]       parity_code,
    input  logic [DIV_W-1:0] div,
    input  logic             line_s,
    input  logic             rx_ack,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_parity_err,
    output logic             rx_frame_err,
    output logic             rx_overrun
);
    frame_state_t     state;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       idx;
    logic [7:0]       shreg;
    logic             perr;
    logic             bit_end;
    logic             done;

    assign bit_end = (cnt == '0);
    assign done    = enable && (state == ST_STOP) && bit_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            perr  <= 1'b0;
        end else if (!enable) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (!line_s) begin
                    cnt   <= (div >> 1) - 1'b1;
                    state <= ST_START;
                end
                ST_START: if (bit_end) begin
                    if (!line_s) begin
                        cnt   <= div - 1'b1;
                        idx   <= '0;
                        shreg <= '0;
                        perr  <= 1'b0;
                        state <= ST_DATA;
                    end else state <= ST_IDLE;
                end else cnt <= cnt - 1'b1;
                ST_DATA: if (bit_end) begin
                    shreg[idx] <= line_s;
                    cnt        <= div - 1'b1;
                    idx        <= idx + 1'b1;
                    if (idx == last_index(width_code))
                        state <= parity_on(parity_code) ? ST_PARITY : ST_STOP;
                end else cnt <= cnt - 1'b1;
                ST_PARITY: if (bit_end) begin
                    perr  <= (line_s != parity_bit(parity_code, shreg));
                    cnt   <= div - 1'b1;
                    state <= ST_STOP;
                end else cnt <= cnt - 1'b1;
                ST_STOP: if (bit_end) state <= ST_IDLE;
                         else cnt <= cnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data       <= '0;
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
            rx_frame_err  <= 1'b0;
            rx_overrun    <= 1'b0;
        end else if (done) begin
            rx_data       <= shreg;
            rx_valid      <= 1'b1;
            rx_parity_err <= perr;
            rx_frame_err  <= !line_s;
            rx_overrun    <= rx_valid && !rx_ack;
        end else if (rx_ack) begin
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
            rx_frame_err  <= 1'b0;
            rx_overrun    <= 1'b0;
        end
    end

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ack) |=> rx_valid);

    assert_ack_clears_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> !rx_overrun);

    assert_disable_idles_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_IDLE));

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
    parameter int DIV_W   = 16,
    parameter int SYNC_ST = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [1:0]           width_code,
    input  logic [2:0]           parity_code,
    input  logic                 two_stop,
    input  logic [2*DIV_W-1:0]   baud_word,
    input  logic [7:0]           tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic                 tx_busy,
    output logic                 tx_line,
    input  logic                 rx_line,
    input  logic                 rx_ack,
    output logic [7:0]           rx_data,
    output logic                 rx_valid,
    output logic                 rx_parity_err,
    output logic                 rx_frame_err,
    output logic                 rx_overrun
);
    localparam int TX_LO = 0;
    localparam int RX_LO = DIV_W;

    logic [DIV_W-1:0] tx_div;
    logic [DIV_W-1:0] rx_div;
    logic             rx_line_s;

    assign tx_div = baud_word[TX_LO +: DIV_W];
    assign rx_div = baud_word[RX_LO +: DIV_W];

    sfe_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .width_code(width_code), .parity_code(parity_code), .two_stop(two_stop),
        .div(tx_div), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_busy(tx_busy), .tx_line(tx_line)
    );

    sfe_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_line_s)
    );

    sfe_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .width_code(width_code), .parity_code(parity_code),
        .div(rx_div), .line_s(rx_line_s), .rx_ack(rx_ack),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
    );
endmodule

// File: tb/uart_frame_engine_bench.sv
module uart_frame_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [1:0]  width_code = 2'd3;
    logic [2:0]  parity_code = 3'd0;
    logic        two_stop = 1'b0;
    logic [31:0] baud_word = {16'd8, 16'd8};
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        rx_ack = 1'b0;
    logic        loop_sel = 1'b1;
    logic        rx_drv = 1'b1;
    logic        tx_ready, tx_busy, tx_line, rx_line;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_parity_err, rx_frame_err, rx_overrun;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign rx_line = loop_sel ? tx_line : rx_drv;

    uart_frame_engine u_uart_frame_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .width_code(width_code), .parity_code(parity_code), .two_stop(two_stop),
        .baud_word(baud_word), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_busy(tx_busy), .tx_line(tx_line),
        .rx_line(rx_line), .rx_ack(rx_ack), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input logic [1:0] wc, input logic [2:0] pc);
        int n;
        int ones;
        n = 5 + int'(wc);
        ones = $countones(d & 8'((1 << n) - 1));
        case (pc)
            3'd4:    return (ones % 2) == 0;
            3'd5:    return 1'b1;
            3'd6:    return (ones % 2) == 1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [11:0] mk_frame(input logic [7:0] d, input logic [1:0] wc, input logic [2:0] pc);
        logic [11:0] f;
        int n;
        n = 5 + int'(wc);
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) f[1+i] = d[i];
        if (pc >= 3'd4) f[1+n] = exp_parity(d, wc, pc);
        return f;
    endfunction

    // Sends one character and checks every bit at its middle and the frame end.
    task automatic send_tx(input logic [7:0] d, input int div);
        logic [11:0] f;
        int n, np, total, tcyc, b;
        string req;
        n = 5 + int'(width_code);
        np = (parity_code >= 3'd4) ? 1 : 0;
        total = 1 + n + np + 1 + int'(two_stop);
        tcyc = total * div;
        f = mk_frame(d, width_code, parity_code);
        tx_data = d;
        tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        for (int j = 1; j <= tcyc + 1; j++) begin
            if (j <= tcyc && ((j - 1) % div) == div / 2) begin
                b = (j - 1) / div;
                if (b <= n) req = "R1 data/start bit";
                else if (b == n + 1 && np == 1) req = "R2 parity bit";
                else req = "R3 stop bit";
                chk(req, {31'd0, tx_line}, {31'd0, (b < 12) ? f[b] : 1'b1});
            end
            if (j == tcyc) begin
                chk("R5 busy in last cycle", {31'd0, tx_busy}, 32'd1);
                chk("R3 not ready before frame end", {31'd0, tx_ready}, 32'd0);
            end
            if (j == tcyc + 1) chk("R3 ready at frame end", {31'd0, tx_ready}, 32'd1);
            if (j <= tcyc) @(negedge clk);
        end
    endtask

    task automatic wait_rx(input int limit);
        for (int k = 0; k < limit && !rx_valid; k++) @(negedge clk);
    endtask

    task automatic ack_rx();
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
    endtask

    task automatic drive_rx(input logic [11:0] f, input int nb, input int div);
        for (int i = 0; i < nb; i++) begin
            rx_drv = f[i];
            repeat (div) @(negedge clk);
        end
        rx_drv = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, all requirements: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] f;
        logic [7:0]  d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset tx_line", {31'd0, tx_line}, 32'd1);
        chk("R5 reset tx_ready", {31'd0, tx_ready}, 32'd1);
        chk("R5 reset tx_busy", {31'd0, tx_busy}, 32'd0);
        chk("R6 reset rx_valid", {31'd0, rx_valid}, 32'd0);

        // Sweep every width, parity code and stop count in loopback.
        for (int wc = 0; wc < 4; wc++)
            for (int pc = 0; pc < 8; pc++)
                for (int ts = 0; ts < 2; ts++)
                    for (int v = 0; v < 2; v++) begin
                        width_code = 2'(wc);
                        parity_code = 3'(pc);
                        two_stop = ts[0];
                        d = (v == 0) ? 8'hA5 : 8'(8'h5A + pc * 7 + wc);
                        send_tx(d, 8);
                        wait_rx(32);
                        chk("R6 rx_valid after loopback", {31'd0, rx_valid}, 32'd1);
                        chk("R6 rx_data zero-extended", {24'd0, rx_data}, {24'd0, d & 8'((1 << (5 + wc)) - 1)});
                        chk("R7 no parity error on clean frame", {31'd0, rx_parity_err}, 32'd0);
                        chk("R8 no frame error on clean frame", {31'd0, rx_frame_err}, 32'd0);
                        chk("R9 no overrun", {31'd0, rx_overrun}, 32'd0);
                        ack_rx();
                        chk("R9 ack clears rx_valid", {31'd0, rx_valid}, 32'd0);
                    end

        // R4: split dividers, transmit 6 cycles per bit, receive 10.
        enable = 1'b0;
        @(negedge clk);
        baud_word = {16'd10, 16'd6};
        width_code = 2'd3; parity_code = 3'd0; two_stop = 1'b0;
        loop_sel = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        send_tx(8'hC3, 6);
        drive_rx(mk_frame(8'h96, 2'd3, 3'd0), 10, 10);
        wait_rx(40);
        chk("R4 rx uses high-half divider", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, 8'h96});
        ack_rx();

        // R7: parity mismatch in even and forced-1 modes.
        enable = 1'b0;
        @(negedge clk);
        baud_word = {16'd8, 16'd8};
        enable = 1'b1;
        parity_code = 3'd6;
        f = mk_frame(8'h0F, 2'd3, 3'd6);
        f[9] = ~f[9];
        drive_rx(f, 11, 8);
        wait_rx(40);
        chk("R7 even parity mismatch flagged", {30'd0, rx_parity_err, rx_frame_err}, 32'd2);
        chk("R7 data kept on parity error", {24'd0, rx_data}, 32'h0F);
        ack_rx();
        parity_code = 3'd5;
        f = mk_frame(8'h33, 2'd3, 3'd5);
        f[9] = 1'b0;
        drive_rx(f, 11, 8);
        wait_rx(40);
        chk("R7 forced-1 parity mismatch flagged", {31'd0, rx_parity_err}, 32'd1);
        ack_rx();

        // R8: stop bit low.
        parity_code = 3'd0;
        f = mk_frame(8'h5C, 2'd3, 3'd0);
        f[9] = 1'b0;
        drive_rx(f, 10, 8);
        wait_rx(40);
        chk("R8 frame error on low stop", {30'd0, rx_parity_err, rx_frame_err}, 32'd1);
        ack_rx();
        repeat (12 * 8) @(negedge clk);
        ack_rx();

        // R10: short glitch then a clean frame.
        rx_drv = 1'b0;
        repeat (2) @(negedge clk);
        rx_drv = 1'b1;
        repeat (24) @(negedge clk);
        chk("R10 glitch rejected", {31'd0, rx_valid}, 32'd0);
        drive_rx(mk_frame(8'h3C, 2'd3, 3'd0), 10, 8);
        wait_rx(40);
        chk("R10 frame after glitch", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, 8'h3C});
        ack_rx();

        // R9: two characters without acknowledge.
        loop_sel = 1'b1;
        send_tx(8'h11, 8);
        wait_rx(32);
        send_tx(8'h22, 8);
        wait_rx(32);
        repeat (4) @(negedge clk);
        chk("R9 overrun flagged", {31'd0, rx_overrun}, 32'd1);
        chk("R9 newer character kept", {24'd0, rx_data}, 32'h22);
        ack_rx();
        chk("R9 ack clears flags", {30'd0, rx_valid, rx_overrun}, 32'd0);

        // R11: enable dropped mid-frame.
        tx_data = 8'h00;
        tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (24) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R11 line high when disabled", {31'd0, tx_line}, 32'd1);
        chk("R11 busy low when disabled", {31'd0, tx_busy}, 32'd0);
        chk("R11 ready low when disabled", {31'd0, tx_ready}, 32'd0);
        enable = 1'b1;
        @(negedge clk);
        chk("R11 ready after re-enable", {31'd0, tx_ready}, 32'd1);
        repeat (12 * 8) @(negedge clk);
        chk("R11 abandoned frame not received", {31'd0, rx_valid}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule